// File: doc/BRIEF.md
# Configurable Approximate Ripple-Carry Adder

This block adds two unsigned operands and a carry-in through a chain of one-bit full-adder cells. The cells in the low-order positions can be switched at run time to one of four approximate behaviours. Each behaviour is a fixed truth table that departs from the exact full adder in a few input combinations. A count input sets how many low-order cells use the chosen behaviour. All cells above that count stay exact, and the carry passes through both regions unchanged.

Error-tolerant datapaths, such as transform stages for image or video coding, use the block to trade numerical accuracy for cheaper arithmetic. They can also use it to study how a given error pattern spreads through a sum. An optional output register, selected by parameter, gives a single-cycle latency. Without it the block is purely combinational.

Top module: `apx_adder`

## Requirements
- R1: With mode code 0 the result {carry_out, sum} equals op_a + op_b + carry_in as a WIDTH+1 bit unsigned sum, for any approximate-bit count.
- R2: Mode code 1 selects a cell whose outputs match the exact cell for all eight (a, b, cin) inputs, so the result equals the exact sum for any count.
- R3: An approximate-bit count of 0 gives the exact sum in every mode.
- R4: Mode codes 5, 6 and 7 behave as mode 0.
- R5: Mode code 2: an approximate cell gives sum 1 for (a,b,cin) = (0,0,0) and (0,1,1). It is exact everywhere else, including its carry, so carry_out always equals the exact carry-out.
- R6: Mode code 3: an approximate cell gives sum 1 for (0,1,1) and carry 0 for (1,1,0). All its other outputs are exact.
- R7: Mode code 4: an approximate cell gives sum 1 for (0,0,0), sum 0 for (0,0,1), sum 1 for (0,1,1) and carry 0 for (1,1,0). All its other outputs are exact.
- R8: Bit position i uses the selected approximate cell only when i is below the effective count. The effective count is approx_bits clamped to MAX_APPROX, which defaults to WIDTH. All other positions are exact, and the carry ripples from bit 0 upward through both regions.
- R9: With REG_OUT = 1, sum and carry_out show the result of the inputs sampled at the previous rising clk edge. While rst_n is low, both outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| mode | input | 3 | Cell behaviour: 0 exact, 1 to 4 variants, 5 to 7 exact |
| approx_bits | input | $clog2(WIDTH+1) | Number of low-order positions using the variant |
| sum | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
On every clock, the assertions check four things. First, the exact-equivalent settings (mode 0, mode 1, fallback codes and a zero count) give plain integer addition. Second, mode 2 never disturbs the carry-out. Third, the position mask is a contiguous run of ones from bit 0, sized to the clamped count. Fourth, the register passes the combinational result one cycle later.

The precise error patterns of modes 3 and 4 can only be shown by the bench scenarios, which compare against an independent per-cell table model. The same holds for how a forced carry of 0 at (1,1,0) spreads into higher exact bits, for clamping of large counts, and for the reset value.

// File: rtl/apx_pkg.sv
package apx_pkg;

   typedef enum logic [2:0] {
      APX_EXACT = 3'd0,
      APX_V1    = 3'd1,
      APX_V2    = 3'd2,
      APX_V3    = 3'd3,
      APX_V4    = 3'd4
   } apx_mode_e;

   // cell input pattern packed as {a, b, cin}
   localparam logic [2:0] PAT_000 = 3'b000;
   localparam logic [2:0] PAT_001 = 3'b001;
   localparam logic [2:0] PAT_011 = 3'b011;
   localparam logic [2:0] PAT_110 = 3'b110;

endpackage

// File: rtl/apx_fa_cell.sv
module apx_fa_cell
   import apx_pkg::*;
#(
   parameter bit EXACT_ONLY = 1'b0
) (
   input  logic       a,
   input  logic       b,
   input  logic       ci,
   input  logic       approx_en,
   input  logic [2:0] mode,
   output logic       s,
   output logic       co
);

   logic s_ex;
   logic c_ex;

   assign s_ex = a ^ b ^ ci;
   assign c_ex = ci ? (a | b) : (a & b);

   generate
      if (EXACT_ONLY) begin : g_exact
         logic unused_sel;
         assign unused_sel = approx_en ^ (^mode);
         assign s  = s_ex;
         assign co = c_ex;
      end else begin : g_config
         logic [2:0] pat;
         assign pat = {a, b, ci};
         always_comb begin
            s  = s_ex;
            co = c_ex;
            if (approx_en) begin
               case (apx_mode_e'(mode))
                  APX_V2: begin
                     if (pat == PAT_000 || pat == PAT_011) s = 1'b1;
                  end
                  APX_V3: begin
                     if (pat == PAT_011) s  = 1'b1;
                     if (pat == PAT_110) co = 1'b0;
                  end
                  APX_V4: begin
                     if (pat == PAT_000) s  = 1'b1;
                     if (pat == PAT_001) s  = 1'b0;
                     if (pat == PAT_011) s  = 1'b1;
                     if (pat == PAT_110) co = 1'b0;
                  end
                  default: ;
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/apx_k_decode.sv
module apx_k_decode #(
   parameter int WIDTH      = 16,
   parameter int MAX_APPROX = WIDTH,
   localparam int CW        = $clog2(WIDTH + 1)
) (
   input  logic [CW-1:0]    k_in,
   output logic [WIDTH-1:0] pos_mask
);

   localparam logic [CW-1:0] K_CAP = CW'(MAX_APPROX);

   logic [CW-1:0] k_eff;
   assign k_eff = (k_in > K_CAP) ? K_CAP : k_in;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pos
         assign pos_mask[i] = (k_eff > CW'(i));
      end
   endgenerate

endmodule

// File: rtl/apx_ripple_core.sv
module apx_ripple_core #(
   parameter int WIDTH      = 16,
   parameter int MAX_APPROX = WIDTH
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   input  logic [2:0]       mode,
   input  logic [WIDTH-1:0] pos_mask,
   output logic [WIDTH-1:0] s,
   output logic             cout
);

   logic [WIDTH:0] chain;
   assign chain[0] = cin;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         apx_fa_cell #(
            .EXACT_ONLY(i >= MAX_APPROX)
         ) u_cell (
            .a        (a[i]),
            .b        (b[i]),
            .ci       (chain[i]),
            .approx_en(pos_mask[i]),
            .mode     (mode),
            .s        (s[i]),
            .co       (chain[i+1])
         );
      end
   endgenerate

   assign cout = chain[WIDTH];

endmodule

// File: rtl/apx_adder.sv
module apx_adder #(
   parameter int WIDTH      = 16,
   parameter int MAX_APPROX = WIDTH,
   parameter bit REG_OUT    = 1'b1,
   localparam int CW        = $clog2(WIDTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   input  logic [2:0]       mode,
   input  logic [CW-1:0]    approx_bits,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("apx_adder: WIDTH must be at least 1");
      end
      if (MAX_APPROX < 0 || MAX_APPROX > WIDTH) begin : g_bad_cap
         $error("apx_adder: MAX_APPROX must lie in 0..WIDTH");
      end
   endgenerate

   logic [WIDTH-1:0] pos_mask;
   logic [WIDTH-1:0] sum_c;
   logic             cout_c;

   apx_k_decode #(
      .WIDTH     (WIDTH),
      .MAX_APPROX(MAX_APPROX)
   ) u_dec (
      .k_in    (approx_bits),
      .pos_mask(pos_mask)
   );

   apx_ripple_core #(
      .WIDTH     (WIDTH),
      .MAX_APPROX(MAX_APPROX)
   ) u_core (
      .a       (op_a),
      .b       (op_b),
      .cin     (carry_in),
      .mode    (mode),
      .pos_mask(pos_mask),
      .s       (sum_c),
      .cout    (cout_c)
   );

   generate
      if (REG_OUT) begin : g_reg
         logic [WIDTH-1:0] sum_q;
         logic             cout_q;
         logic             past_ok;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sum_q   <= '0;
               cout_q  <= 1'b0;
               past_ok <= 1'b0;
            end else begin
               sum_q   <= sum_c;
               cout_q  <= cout_c;
               past_ok <= 1'b1;
            end
         end
         assign sum       = sum_q;
         assign carry_out = cout_q;

         assert_reg_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok |-> ({carry_out, sum} == $past({cout_c, sum_c})));
      end else begin : g_comb
         assign sum       = sum_c;
         assign carry_out = cout_c;
      end
   endgenerate

   // ---------------- assertions ----------------
   localparam logic [CW-1:0] K_CAP = CW'(MAX_APPROX);

   logic [WIDTH:0] int_sum;
   logic [CW-1:0]  k_clamped;
   assign int_sum   = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
   assign k_clamped = (approx_bits > K_CAP) ? K_CAP : approx_bits;

   assert_mode0_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd0) |-> ({cout_c, sum_c} == int_sum));

   assert_mode1_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd1) |-> ({cout_c, sum_c} == int_sum));

   assert_k_zero_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (approx_bits == '0) |-> ({cout_c, sum_c} == int_sum));

   assert_fallback_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode >= 3'd5) |-> ({cout_c, sum_c} == int_sum));

   assert_mode2_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd2) |-> (cout_c == int_sum[WIDTH]));

   assert_mask_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pos_mask + 1'b1) && ($countones(pos_mask) == int'(k_clamped)));

endmodule

// File: tb/tb_apx_adder.sv
`timescale 1ns/1ps
module tb_apx_adder;

   localparam int W  = 16;
   localparam int CW = $clog2(W + 1);

   logic          clk = 1'b0;
   logic          rst_n;
   logic [W-1:0]  op_a, op_b;
   logic          carry_in;
   logic [2:0]    mode;
   logic [CW-1:0] approx_bits;
   logic [W-1:0]  sum;
   logic          carry_out;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   apx_adder #(.WIDTH(W), .MAX_APPROX(W), .REG_OUT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .carry_in(carry_in), .mode(mode), .approx_bits(approx_bits),
      .sum(sum), .carry_out(carry_out)
   );

   typedef struct packed {
      logic [15:0] a;
      logic [15:0] b;
      logic        ci;
      logic [2:0]  m;
      logic [4:0]  k;
      logic [15:0] es;
      logic        ec;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{16'h1234, 16'h4321, 1'b0, 3'd0, 5'd16, 16'h5555, 1'b0},  // R1
      '{16'hFFFF, 16'h0001, 1'b0, 3'd0, 5'd16, 16'h0000, 1'b1},  // R1
      '{16'h8000, 16'h8000, 1'b1, 3'd1, 5'd16, 16'h0001, 1'b1},  // R2
      '{16'h0000, 16'h0000, 1'b0, 3'd4, 5'd0,  16'h0000, 1'b0},  // R3
      '{16'hFFFF, 16'hFFFF, 1'b1, 3'd7, 5'd16, 16'hFFFF, 1'b1},  // R4
      '{16'h0000, 16'h0000, 1'b0, 3'd2, 5'd16, 16'hFFFF, 1'b0},  // R5
      '{16'h0000, 16'h0001, 1'b1, 3'd2, 5'd1,  16'h0003, 1'b0},  // R5
      '{16'h0003, 16'h0003, 1'b0, 3'd3, 5'd2,  16'h0000, 1'b0},  // R6
      '{16'h0003, 16'h0003, 1'b0, 3'd3, 5'd1,  16'h0004, 1'b0},  // R6
      '{16'h0000, 16'h0000, 1'b1, 3'd4, 5'd1,  16'h0000, 1'b0},  // R7
      '{16'h0000, 16'h0000, 1'b0, 3'd4, 5'd16, 16'hFFFF, 1'b0},  // R7
      '{16'h0000, 16'h0000, 1'b0, 3'd4, 5'd31, 16'hFFFF, 1'b0}   // R8 clamp
   };

   function automatic string vec_tag(int i);
      case (i)
         0, 1:    return "R1";
         2:       return "R2";
         3:       return "R3";
         4:       return "R4";
         5, 6:    return "R5";
         7, 8:    return "R6";
         9, 10:   return "R7";
         default: return "R8";
      endcase
   endfunction

   // {s, c} per cell, index {a, b, cin}
   function automatic logic [1:0] cell_tab(logic [2:0] m, logic [2:0] idx);
      logic [1:0] r;
      case (idx)
         3'd0: r = 2'b00;  3'd1: r = 2'b10;
         3'd2: r = 2'b10;  3'd3: r = 2'b01;
         3'd4: r = 2'b10;  3'd5: r = 2'b01;
         3'd6: r = 2'b01;  default: r = 2'b11;
      endcase
      if (m == 3'd2) begin
         if (idx == 3'd0) r = 2'b10;
         if (idx == 3'd3) r = 2'b11;
      end else if (m == 3'd3) begin
         if (idx == 3'd3) r = 2'b11;
         if (idx == 3'd6) r = 2'b00;
      end else if (m == 3'd4) begin
         if (idx == 3'd0) r = 2'b10;
         if (idx == 3'd1) r = 2'b00;
         if (idx == 3'd3) r = 2'b11;
         if (idx == 3'd6) r = 2'b00;
      end
      return r;
   endfunction

   function automatic logic [W:0] ref_add(logic [W-1:0] a, logic [W-1:0] b,
                                          logic ci, logic [2:0] m, int k);
      logic c = ci;
      logic [W-1:0] s = '0;
      logic [1:0] sc;
      int kk = (k > W) ? W : k;
      for (int i = 0; i < W; i++) begin
         sc   = cell_tab((i < kk) ? m : 3'd0, {a[i], b[i], c});
         s[i] = sc[1];
         c    = sc[0];
      end
      return {c, s};
   endfunction

   task automatic check(string tag, logic [W:0] got, logic [W:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic ci,
                        logic [2:0] m, logic [CW-1:0] k);
      @(negedge clk);
      op_a = a; op_b = b; carry_in = ci; mode = m; approx_bits = k;
      @(negedge clk);
   endtask

   logic [31:0] rng = 32'h1BADF00D;
   function automatic logic [31:0] next_rng(logic [31:0] x);
      logic [31:0] y = x;
      y ^= y << 13; y ^= y >> 17; y ^= y << 5;
      return y;
   endfunction

   initial begin
      #(4ns * 190000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      op_a = 16'hA5A5; op_b = 16'h5A5A; carry_in = 1'b1;
      mode = 3'd0; approx_bits = '0;
      repeat (3) @(negedge clk);
      check("R9 reset value", {carry_out, sum}, '0);
      rst_n = 1'b1;

      // vector table
      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].a, VECS[i].b, VECS[i].ci, VECS[i].m, VECS[i].k);
         check(vec_tag(i), {carry_out, sum}, {VECS[i].ec, VECS[i].es});
      end

      // R9: output holds until the next rising edge
      apply(16'h0001, 16'h0001, 1'b0, 3'd0, 5'd0);
      op_a = 16'h0100; op_b = 16'h0100;
      #1;
      check("R9 holds before edge", {carry_out, sum}, 17'h00002);
      @(negedge clk);
      check("R9 one cycle later", {carry_out, sum}, 17'h00200);

      // sweep: every mode against the per-cell table model (R5 R6 R7 R8)
      for (int m = 0; m < 8; m++) begin
         for (int ki = 0; ki < 6; ki++) begin
            int k;
            case (ki)
               0: k = 0; 1: k = 1; 2: k = 5; 3: k = 8; 4: k = 16; default: k = 31;
            endcase
            for (int n = 0; n < 16; n++) begin
               logic [W-1:0] a, b;
               logic ci;
               rng = next_rng(rng); a = rng[15:0]; b = rng[31:16];
               rng = next_rng(rng); ci = rng[3];
               apply(a, b, ci, 3'(m), CW'(k));
               check("R8 model sweep", {carry_out, sum}, ref_add(a, b, ci, 3'(m), k));
               if (m == 0 || m == 1 || m >= 5 || k == 0)
                  check("R1 R2 R3 R4 integer add", {carry_out, sum},
                        {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci});
            end
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule